// File: doc/BRIEF.md
# Packed 9-bit Symbol Error Patcher

This block repairs a 512-byte buffer after a Reed-Solomon decoder has located the errors in it. The buffer is seen as a continuous bit stream cut into 9-bit symbols, so a symbol usually straddles two bytes. The decoder hands over a status word: an error flag, an uncorrectable flag, a report count and four slots. Each slot holds a symbol index and a 9-bit XOR mask. On a start pulse the block latches that status. It then walks the counted slots and, for each one, reads the two bytes that hold the symbol from an external byte-wide synchronous RAM. It XORs the mask into the right bit field and writes both bytes back.

The RAM port has a read enable, a write enable, one shared address and a read latency of one cycle. A single-cycle done pulse marks the end of a patch run. A single-cycle fail pulse replaces it when the decoder reported the block as uncorrectable, and in that case the RAM is not touched. The block owns the RAM port only while it is busy, so the surrounding logic is free to read the repaired buffer once done has been seen.

Top module: `rsp_sym_patcher`

## Requirements
- R1: For symbol index k, let p = 9k - 1. The high byte address is i = floor(p/8) and the field shift is j = p mod 8. Bytes i and i-1 form a 16-bit word, with byte i in bits 15:8 and byte i-1 in bits 7:0. The 9-bit mask is XORed into bits j+8 down to j. Bits 7:0 are written back to byte i-1 and bits 15:8 to byte i, and every other bit keeps its value.
- R2: A report whose high byte address is 512 or more is skipped and causes no RAM access. Index 0, whose high byte address is -1, is also skipped.
- R3: err_cnt gives the number of slots used, starting at slot 0 and taking the slots in ascending order. A value above 4 counts as 4. A value of 0 performs no fixes.
- R4: With err_flag low and uncor_flag low, no RAM access takes place and done pulses in the second cycle after the start is accepted.
- R5: With uncor_flag high when the start is accepted, no RAM access takes place. fail pulses for one cycle right after the accept, and done stays low.
- R6: done is a one-cycle pulse. busy is high from the cycle after the accept through the done or fail cycle, and it is low again in the next cycle.
- R7: A start that arrives while busy is high, including the done cycle, is ignored. The status inputs are sampled only at an accepted start.
- R8: A fix that is applied takes five cycles: one selection cycle, then a read of byte i-1, a read of byte i, a write of byte i-1 and a write of byte i, on consecutive cycles. A skipped slot takes one cycle. mem_rdata is expected one cycle after mem_re. done falls in cycle 5*applied + skipped + 2 after the accept.
- R9: Reports that touch the same or neighbouring bytes compose: each fix reads the bytes that the earlier fixes of the same run have written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a patch run; accepted only when idle |
| err_flag | input | 1 | Decoder found errors |
| uncor_flag | input | 1 | Decoder cannot correct this block |
| err_cnt | input | 3 | Number of valid slots (clamped to 4) |
| err_idx | input | 40 | Four 10-bit symbol indices, slot n at bits 10n+9:10n |
| err_mask | input | 36 | Four 9-bit XOR masks, slot n at bits 9n+8:9n |
| mem_re | output | 1 | RAM read enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 9 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid one cycle after mem_re |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a patch run |
| fail | output | 1 | One-cycle pulse when the block was uncorrectable |

## Verification
Two collisions are provoked on purpose. The first is a new start driven during the very cycle that raises done. The second is a start carrying an uncorrectable status that arrives in the middle of a read-modify-write. In both cases the bench expects the intruding request to leave no trace: there must be no fail pulse, no extra done, no busy in the following cycles, and a final buffer that equals the reference built only from the status sampled at the accepted start. Reports that overlap on shared bytes within one run are also mixed in, so that a write from one fix and the read of the next fix meet back to back. Those runs are judged against the sequential reference.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int SYM_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_RD_LO, ST_RD_HI, ST_WR_LO, ST_WR_HI, ST_FIN, ST_FAIL
  } rsp_state_e;

  // move a 9-bit mask into its place inside the 16-bit byte pair
  function automatic logic [15:0] place_mask(logic [SYM_W-1:0] m, logic [2:0] sh);
    return {7'b0, m} << sh;
  endfunction
endpackage

// File: rtl/rsp_sym_map.sv
module rsp_sym_map #(
  parameter int IDXW      = 10,
  parameter int BUF_BYTES = 512,
  parameter int AW        = 9
) (
  input  logic [IDXW-1:0] idx,
  output logic [AW-1:0]   hi_addr,
  output logic [AW-1:0]   lo_addr,
  output logic [2:0]      shift,
  output logic            in_range
);
  localparam int PW = IDXW + 4;
  localparam int BW = PW - 3;

  function automatic logic [PW-1:0] times9(logic [IDXW-1:0] k);
    return {4'b0, k} + {1'b0, k, 3'b0};
  endfunction

  logic [PW-1:0] prod;
  logic [BW-1:0] base, hi;
  logic [2:0]    frac;

  assign prod     = times9(idx);
  assign base     = prod[PW-1:3];
  assign frac     = prod[2:0];
  // a zero remainder pulls the field into the previous byte pair
  assign hi       = (frac == 3'd0) ? base - BW'(1) : base;
  assign shift    = (frac == 3'd0) ? 3'd7 : frac - 3'd1;
  assign in_range = hi < BW'(BUF_BYTES);
  assign hi_addr  = hi[AW-1:0];
  assign lo_addr  = hi_addr - AW'(1);
endmodule

// File: rtl/rsp_ctrl.sv
module rsp_ctrl
  import rsp_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int AW    = 9,
  parameter int SLW   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go,
  input  logic                        go_fail,
  input  logic [SLW-1:0]              cnt,
  input  logic [SLOTS-1:0][AW-1:0]    hi_addr,
  input  logic [SLOTS-1:0][AW-1:0]    lo_addr,
  input  logic [SLOTS-1:0][2:0]       shift,
  input  logic [SLOTS-1:0]            in_range,
  input  logic [SLOTS-1:0][SYM_W-1:0] mask,
  input  logic [7:0]                  mem_rdata,
  output logic                        mem_re,
  output logic                        mem_we,
  output logic [AW-1:0]               mem_addr,
  output logic [7:0]                  mem_wdata,
  output logic                        idle,
  output logic                        busy,
  output logic                        done,
  output logic                        fail,
  output logic                        evt_skip
);
  rsp_state_e     state;
  logic [SLW-1:0] slot;
  logic [7:0]     lo_q, hi_q;

  logic [AW-1:0]  cur_hi, cur_lo;
  logic [2:0]     cur_sh;
  logic           cur_in;
  logic [SYM_W-1:0] cur_mask;
  logic [15:0]    xm;

  always_comb begin
    cur_hi = '0; cur_lo = '0; cur_sh = '0; cur_in = 1'b0; cur_mask = '0;
    for (int n = 0; n < SLOTS; n++) begin
      if (slot == SLW'(n)) begin
        cur_hi = hi_addr[n]; cur_lo = lo_addr[n]; cur_sh = shift[n];
        cur_in = in_range[n]; cur_mask = mask[n];
      end
    end
  end

  assign xm       = place_mask(cur_mask, cur_sh);
  assign idle     = (state == ST_IDLE);
  assign busy     = !idle;
  assign done     = (state == ST_FIN);
  assign fail     = (state == ST_FAIL);
  assign evt_skip = (state == ST_SEL) && (slot != cnt) && !cur_in;

  always_comb begin
    mem_re = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    unique case (state)
      ST_RD_LO: begin mem_re = 1'b1; mem_addr = cur_lo; end
      ST_RD_HI: begin mem_re = 1'b1; mem_addr = cur_hi; end
      ST_WR_LO: begin mem_we = 1'b1; mem_addr = cur_lo; mem_wdata = lo_q ^ xm[7:0]; end
      ST_WR_HI: begin mem_we = 1'b1; mem_addr = cur_hi; mem_wdata = hi_q ^ xm[15:8]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      slot  <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          slot <= '0;
          if (go_fail)  state <= ST_FAIL;
          else if (go)  state <= ST_SEL;
        end
        ST_SEL: begin
          if (slot == cnt)  state <= ST_FIN;
          else if (!cur_in) slot  <= slot + SLW'(1);
          else              state <= ST_RD_LO;
        end
        ST_RD_LO: state <= ST_RD_HI;
        ST_RD_HI: begin lo_q <= mem_rdata; state <= ST_WR_LO; end
        ST_WR_LO: begin hi_q <= mem_rdata; state <= ST_WR_HI; end
        ST_WR_HI: begin slot <= slot + SLW'(1); state <= ST_SEL; end
        ST_FIN:  state <= ST_IDLE;
        ST_FAIL: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsp_sym_patcher.sv
module rsp_sym_patcher
  import rsp_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int IDXW      = 10,
  parameter int BUF_BYTES = 512,
  parameter int AW        = $clog2(BUF_BYTES),
  parameter int CNT_W     = $clog2(SLOTS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     err_flag,
  input  logic                     uncor_flag,
  input  logic [CNT_W-1:0]         err_cnt,
  input  logic [SLOTS*IDXW-1:0]    err_idx,
  input  logic [SLOTS*SYM_W-1:0]   err_mask,
  output logic                     mem_re,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [7:0]               mem_wdata,
  input  logic [7:0]               mem_rdata,
  output logic                     busy,
  output logic                     done,
  output logic                     fail
);
  logic                        idle, evt_accept, evt_skip;
  logic [CNT_W-1:0]            cnt_q;
  logic [SLOTS-1:0][IDXW-1:0]  idx_q;
  logic [SLOTS-1:0][SYM_W-1:0] mask_q;
  logic [SLOTS-1:0][AW-1:0]    hi_addr, lo_addr;
  logic [SLOTS-1:0][2:0]       shift;
  logic [SLOTS-1:0]            in_range;

  assign evt_accept = start && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
      mask_q <= '0;
    end else if (evt_accept) begin
      if (!err_flag)                      cnt_q <= '0;
      else if (err_cnt > CNT_W'(SLOTS))   cnt_q <= CNT_W'(SLOTS);
      else                                cnt_q <= err_cnt;
      for (int n = 0; n < SLOTS; n++) begin
        idx_q[n]  <= err_idx[n*IDXW +: IDXW];
        mask_q[n] <= err_mask[n*SYM_W +: SYM_W];
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_map
    rsp_sym_map #(.IDXW(IDXW), .BUF_BYTES(BUF_BYTES), .AW(AW)) i_map (
      .idx(idx_q[g]), .hi_addr(hi_addr[g]), .lo_addr(lo_addr[g]),
      .shift(shift[g]), .in_range(in_range[g])
    );
  end

  rsp_ctrl #(.SLOTS(SLOTS), .AW(AW), .SLW(CNT_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .go(evt_accept && !uncor_flag), .go_fail(evt_accept && uncor_flag),
    .cnt(cnt_q), .hi_addr(hi_addr), .lo_addr(lo_addr), .shift(shift),
    .in_range(in_range), .mask(mask_q), .mem_rdata(mem_rdata),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .idle(idle), .busy(busy), .done(done), .fail(fail), .evt_skip(evt_skip)
  );
endmodule

// File: rtl/rsp_sym_patcher_chk.sv
module rsp_sym_patcher_chk (
  input logic clk,
  input logic rst_n,
  input logic err_flag,
  input logic uncor_flag,
  input logic busy,
  input logic done,
  input logic fail,
  input logic mem_re,
  input logic mem_we,
  input logic evt_accept,
  input logic evt_skip
);
  p_uncor_no_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept && uncor_flag |=> fail && !mem_we && !mem_re);
  p_no_done_with_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  p_clean_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept && !err_flag && !uncor_flag |=> ##1 done);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  p_write_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_re));
  p_rw_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we && !mem_re);
  p_skip_no_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_skip |=> !mem_we);
endmodule

bind rsp_sym_patcher rsp_sym_patcher_chk i_chk (
  .clk(clk), .rst_n(rst_n), .err_flag(err_flag), .uncor_flag(uncor_flag),
  .busy(busy), .done(done), .fail(fail), .mem_re(mem_re), .mem_we(mem_we),
  .evt_accept(evt_accept), .evt_skip(evt_skip)
);

// File: tb/test_rsp_sym_patcher.sv
module test_rsp_sym_patcher;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, err_flag = 1'b0, uncor_flag = 1'b0;
  logic [2:0]  err_cnt = '0;
  logic [39:0] err_idx = '0;
  logic [35:0] err_mask = '0;
  logic mem_re, mem_we, busy, done, fail;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;

  logic [7:0] ram [NB];
  logic [7:0] expm [NB];
  int wr_total = 0;
  int n_chk = 0, n_bad = 0;
  int c_idx [4];
  int c_msk [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  rsp_sym_patcher i_rsp_sym_patcher (
    .clk(clk), .rst_n(rst_n), .start(start), .err_flag(err_flag),
    .uncor_flag(uncor_flag), .err_cnt(err_cnt), .err_idx(err_idx),
    .err_mask(err_mask), .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .fail(fail)
  );

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= ram[mem_addr];
    if (mem_we) begin ram[mem_addr] <= mem_wdata; wr_total <= wr_total + 1; end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endfunction

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  // poke: 0 none, 1 uncorrectable start mid-run, 2 start in the done cycle
  task automatic run_case(string tag, bit ef, bit uf, int cnt, int poke);
    int eff, app, skp, cyc, w0, p, bi, sh, exp_cyc, bad_at;
    logic [15:0] word;
    eff = ef ? ((cnt > 4) ? 4 : cnt) : 0;
    app = 0; skp = 0;
    for (int b = 0; b < NB; b++) expm[b] = ram[b];
    if (!uf) begin
      for (int n = 0; n < eff; n++) begin
        p  = 9 * c_idx[n] - 1;
        bi = p >>> 3;
        sh = p & 7;
        if (bi < 1 || bi >= NB) skp++;
        else begin
          word = {expm[bi], expm[bi-1]} ^ (16'(c_msk[n]) << sh);
          expm[bi-1] = word[7:0];
          expm[bi]   = word[15:8];
          app++;
        end
      end
    end
    exp_cyc = uf ? 1 : 5 * app + skp + 2;
    @(negedge clk);
    err_flag = ef; uncor_flag = uf; err_cnt = 3'(cnt);
    for (int n = 0; n < 4; n++) begin
      err_idx[n*10 +: 10] = 10'(c_idx[n]);
      err_mask[n*9 +: 9]  = 9'(c_msk[n]);
    end
    start = 1'b1;
    w0 = wr_total;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && !fail && cyc < 100) begin
      if (poke == 1 && cyc == 2) begin
        start = 1'b1; uncor_flag = 1'b1; err_flag = 1'b0; err_cnt = '0;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (uf) check(fail && !done, {tag, " R5 fail pulse"}, {30'd0, fail, done}, 2);
    else    check(done && !fail, {tag, " R6/R7 done pulse"}, {30'd0, fail, done}, 1);
    check(cyc == exp_cyc, {tag, " R8 run length"}, cyc, exp_cyc);
    if (poke == 2) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!busy && !done && !fail, {tag, " R6/R7 idle after end"},
          {29'd0, busy, done, fail}, 0);
    @(negedge clk);
    check(!busy && !done && !fail, {tag, " R7 late start ignored"},
          {29'd0, busy, done, fail}, 0);
    check(wr_total - w0 == 2 * app, {tag, " R2/R3 write count"}, wr_total - w0, 2 * app);
    bad_at = -1;
    for (int b = NB - 1; b >= 0; b--) if (ram[b] !== expm[b]) bad_at = b;
    if (bad_at >= 0)
      check(0, {tag, " R1/R9 buffer byte"}, int'(ram[bad_at]), int'(expm[bad_at]));
    else
      check(1, {tag, " R1/R9 buffer"}, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h0051_7a3d));
    for (int b = 0; b < NB; b++) ram[b] = 8'($urandom);
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !mem_we && !mem_re, "reset state",
          {27'd0, busy, done, fail, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: first symbol after index 0 touches bytes 0 and 1
    c_idx = '{1, 0, 0, 0}; c_msk = '{9'h1FF, 0, 0, 0};
    run_case("r1_first", 1, 0, 1, 0);
    // R1: zero remainder case, field at shift 7 across bytes 7 and 8
    c_idx = '{8, 16, 0, 0}; c_msk = '{9'h101, 9'h0AA, 0, 0};
    run_case("r1_wrap", 1, 0, 2, 0);
    // R2: index 0, index 456 (byte 512) skipped; 455 is the last valid
    c_idx = '{0, 456, 455, 700}; c_msk = '{9'h1FF, 9'h1FF, 9'h155, 9'h1FF};
    run_case("r2_range", 1, 0, 4, 0);
    // R3: count above 4 clamps; count 2 ignores slots 2 and 3
    c_idx = '{10, 20, 30, 40}; c_msk = '{9'h001, 9'h100, 9'h0F0, 9'h10F};
    run_case("r3_clamp", 1, 0, 7, 0);
    run_case("r3_partial", 1, 0, 2, 0);
    run_case("r3_zero", 1, 0, 0, 0);
    // R9: overlapping reports on shared bytes
    c_idx = '{5, 5, 6, 4}; c_msk = '{9'h1C3, 9'h03C, 9'h1FF, 9'h0FF};
    run_case("r9_overlap", 1, 0, 4, 0);
    // R4: no error flag
    run_case("r4_clean", 0, 0, 4, 0);
    // R5: uncorrectable
    run_case("r5_uncor", 1, 1, 4, 0);
    // R7: intruding starts
    c_idx = '{100, 101, 300, 301}; c_msk = '{9'h1AB, 9'h0CD, 9'h111, 9'h022};
    run_case("r7_midrun", 1, 0, 4, 1);
    run_case("r7_donecyc", 1, 0, 3, 2);

    for (int t = 0; t < 40; t++) begin
      for (int n = 0; n < 4; n++) begin
        c_idx[n] = ($urandom_range(0, 9) < 8) ? int'($urandom_range(1, 470))
                                               : int'($urandom_range(0, 1023));
        c_msk[n] = int'($urandom_range(0, 511));
      end
      run_case("rand", ($urandom_range(0, 7) != 0), ($urandom_range(0, 11) == 0),
               int'($urandom_range(0, 7)), int'($urandom_range(0, 5) == 0 ? 2 : 0));
    end

    summary();
    $finish;
  end
endmodule